// File: doc/BRIEF.md
# Ready-Time Gated Stage Transfer

This block sits between two bounded buffers of an execution pipeline, for example between an issue buffer and a decode buffer. It holds the source buffer itself as an ordered, compacting queue of entries. Each entry carries a tag and the cycle at which it becomes ready. Every cycle it looks at the entries that were present at the start of that cycle, from oldest to newest. It hands the ones that may advance to the destination buffer through a set of enqueue lanes. Each advancing entry is stamped with a new ready cycle: the current cycle plus a fixed stage latency.

The lookup is limited by a width budget, and every entry looked at uses up one unit of that budget, including an entry that cannot advance. Entries that are not ready, or that meet a full destination, stay where they are, and the scan goes on to the next entry. As a result, a younger entry can pass an older blocked one. The upstream stage appends new entries through a push port. It reads the current occupancy so that it never pushes into a full queue. The destination reports how full it is, and it accepts every lane marked valid in the same cycle.

Top module: `latency_stage_xfer`

## Requirements
- R1: During and right after reset the source occupancy is 0 and no enqueue lane is valid.
- R2: Only the oldest WIDTH entries of the source are candidates in a cycle. Each of them uses up one unit of the width whether or not it advances, so no entry at position WIDTH or beyond (position 0 being the oldest) advances in that cycle.
- R3: An entry whose stored ready cycle is greater than `cycle_i` does not advance. A later candidate that is ready may still advance in the same cycle.
- R4: Within the candidates, an entry advances only if `dst_count_i` plus the number of entries already advancing this cycle is below DST_DEPTH. An entry that is held back by this rule keeps its place in the source.
- R5: Advancing entries appear on lanes 0, 1, … in source order, oldest first, with no gaps. Lane k uses bits [k*TAG_W +: TAG_W] of `enq_tag_o` and [k*TIME_W +: TIME_W] of `enq_time_o`.
- R6: At the clock edge, the advancing entries leave the source and the remaining entries close up in their original order. An accepted push is appended after them. A pushed entry is not a candidate until the next cycle.
- R7: The source occupancy never exceeds SRC_DEPTH. A push is accepted only when fewer than SRC_DEPTH entries remain after this cycle's departures.
- R8: The ready cycle presented with an advancing entry equals `cycle_i` + LATENCY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_i | input | TIME_W | Current cycle number |
| push_valid_i | input | 1 | Append an entry to the source queue |
| push_tag_i | input | TAG_W | Tag of the appended entry |
| push_time_i | input | TIME_W | Ready cycle of the appended entry |
| dst_count_i | input | $clog2(DST_DEPTH+1) | Current destination occupancy |
| src_count_o | output | $clog2(SRC_DEPTH+1) | Current source occupancy |
| enq_valid_o | output | WIDTH | Per-lane enqueue strobe to the destination |
| enq_tag_o | output | WIDTH*TAG_W | Per-lane tag |
| enq_time_o | output | WIDTH*TIME_W | Per-lane new ready cycle |

## Verification
Two things can happen in the same cycle: entries leave the queue, and an entry is pushed onto it. The compacted survivors and the new tail entry then have to land in the right slots together. The bench pushes on most cycles while the destination fill level cycles through every value from empty to full, and ready offsets of up to six cycles make older entries block while younger ones advance. A reference queue in the bench applies the departures first and then the append. It is compared every cycle against the occupancy and the lane contents, so any misplaced survivor or pushed entry shows up as a wrong tag on a later cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   function automatic int occ_bits(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/xfer_scan.sv
module xfer_scan #(
   parameter int SRC_DEPTH = 4,
   parameter int DST_DEPTH = 3,
   parameter int WIDTH     = 2,
   parameter int TIME_W    = 16,
   parameter int CNT_W     = 3,
   parameter int DCNT_W    = 2
) (
   input  logic [CNT_W-1:0]  src_cnt_i,
   input  logic [TIME_W-1:0] rt_i [SRC_DEPTH],
   input  logic [TIME_W-1:0] now_i,
   input  logic [DCNT_W-1:0] dst_cnt_i,
   output logic [SRC_DEPTH-1:0] move_o
);
   logic [SRC_DEPTH-1:0] elig;

   for (genvar i = 0; i < SRC_DEPTH; i++) begin : g_slot
      if (i < WIDTH) begin : g_window
         assign elig[i] = (i < int'(src_cnt_i)) && (rt_i[i] <= now_i);
      end else begin : g_beyond
         assign elig[i] = 1'b0;
      end
   end

   always_comb begin
      int taken;
      taken  = 0;
      move_o = '0;
      for (int i = 0; i < SRC_DEPTH; i++) begin
         if (elig[i] && (int'(dst_cnt_i) + taken < DST_DEPTH)) begin
            move_o[i] = 1'b1;
            taken     = taken + 1;
         end
      end
   end
endmodule

// File: rtl/xfer_lanes.sv
module xfer_lanes #(
   parameter int SRC_DEPTH = 4,
   parameter int WIDTH     = 2,
   parameter int TAG_W     = 4,
   parameter int TIME_W    = 16,
   parameter int LATENCY   = 3
) (
   input  logic [SRC_DEPTH-1:0] move_i,
   input  logic [TAG_W-1:0]     tag_i [SRC_DEPTH],
   input  logic [TIME_W-1:0]    now_i,
   output logic [WIDTH-1:0]        valid_o,
   output logic [WIDTH*TAG_W-1:0]  tag_o,
   output logic [WIDTH*TIME_W-1:0] time_o
);
   localparam logic [TIME_W-1:0] LAT_T = TIME_W'(LATENCY);
   logic [TIME_W-1:0] stamp;

   assign stamp = now_i + LAT_T;

   always_comb begin
      int m;
      m       = 0;
      valid_o = '0;
      tag_o   = '0;
      time_o  = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (move_i[i]) begin
            for (int k = 0; k < WIDTH; k++) begin
               if (k == m) begin
                  valid_o[k]                 = 1'b1;
                  tag_o[k*TAG_W +: TAG_W]    = tag_i[i];
                  time_o[k*TIME_W +: TIME_W] = stamp;
               end
            end
            m = m + 1;
         end
      end
   end
endmodule

// File: rtl/xfer_compact.sv
module xfer_compact #(
   parameter int SRC_DEPTH = 4,
   parameter int TAG_W     = 4,
   parameter int TIME_W    = 16,
   parameter int CNT_W     = 3
) (
   input  logic [CNT_W-1:0]     cnt_i,
   input  logic [SRC_DEPTH-1:0] move_i,
   input  logic [TAG_W-1:0]     tag_i [SRC_DEPTH],
   input  logic [TIME_W-1:0]    rt_i  [SRC_DEPTH],
   input  logic                 push_i,
   input  logic [TAG_W-1:0]     push_tag_i,
   input  logic [TIME_W-1:0]    push_rt_i,
   output logic [TAG_W-1:0]     tag_o [SRC_DEPTH],
   output logic [TIME_W-1:0]    rt_o  [SRC_DEPTH],
   output logic [CNT_W-1:0]     cnt_o
);
   always_comb begin
      int k;
      k = 0;
      for (int j = 0; j < SRC_DEPTH; j++) begin
         tag_o[j] = tag_i[j];
         rt_o[j]  = rt_i[j];
      end
      for (int i = 0; i < SRC_DEPTH; i++) begin
         if ((i < int'(cnt_i)) && !move_i[i]) begin
            for (int j = 0; j < SRC_DEPTH; j++) begin
               if (j == k) begin
                  tag_o[j] = tag_i[i];
                  rt_o[j]  = rt_i[i];
               end
            end
            k = k + 1;
         end
      end
      if (push_i && (k < SRC_DEPTH)) begin
         for (int j = 0; j < SRC_DEPTH; j++) begin
            if (j == k) begin
               tag_o[j] = push_tag_i;
               rt_o[j]  = push_rt_i;
            end
         end
         k = k + 1;
      end
      cnt_o = CNT_W'(k);
   end
endmodule

// File: rtl/latency_stage_xfer.sv
module latency_stage_xfer #(
   parameter int SRC_DEPTH = 4,
   parameter int DST_DEPTH = 3,
   parameter int WIDTH     = 2,
   parameter int LATENCY   = 3,
   parameter int TAG_W     = 4,
   parameter int TIME_W    = 16,
   localparam int CNT_W    = xfer_pkg::occ_bits(SRC_DEPTH),
   localparam int DCNT_W   = xfer_pkg::occ_bits(DST_DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [TIME_W-1:0]       cycle_i,
   input  logic                    push_valid_i,
   input  logic [TAG_W-1:0]        push_tag_i,
   input  logic [TIME_W-1:0]       push_time_i,
   input  logic [DCNT_W-1:0]       dst_count_i,
   output logic [CNT_W-1:0]        src_count_o,
   output logic [WIDTH-1:0]        enq_valid_o,
   output logic [WIDTH*TAG_W-1:0]  enq_tag_o,
   output logic [WIDTH*TIME_W-1:0] enq_time_o
);
   if (SRC_DEPTH < 2) begin : g_bad_src
      $error("SRC_DEPTH must be at least 2");
   end
   if (DST_DEPTH < 1) begin : g_bad_dst
      $error("DST_DEPTH must be at least 1");
   end
   if ((WIDTH < 1) || (WIDTH > SRC_DEPTH)) begin : g_bad_width
      $error("WIDTH must lie in 1..SRC_DEPTH");
   end
   if ((LATENCY < 0) || (TAG_W < 1) || (TIME_W < 2)) begin : g_bad_field
      $error("LATENCY, TAG_W or TIME_W out of range");
   end

   logic [TAG_W-1:0]     tag_q  [SRC_DEPTH];
   logic [TIME_W-1:0]    rt_q   [SRC_DEPTH];
   logic [TAG_W-1:0]     tag_d  [SRC_DEPTH];
   logic [TIME_W-1:0]    rt_d   [SRC_DEPTH];
   logic [CNT_W-1:0]     cnt_q, cnt_d;
   logic [SRC_DEPTH-1:0] move;

   xfer_scan #(
      .SRC_DEPTH(SRC_DEPTH), .DST_DEPTH(DST_DEPTH), .WIDTH(WIDTH),
      .TIME_W(TIME_W), .CNT_W(CNT_W), .DCNT_W(DCNT_W)
   ) u_scan (
      .src_cnt_i(cnt_q), .rt_i(rt_q), .now_i(cycle_i),
      .dst_cnt_i(dst_count_i), .move_o(move)
   );

   xfer_lanes #(
      .SRC_DEPTH(SRC_DEPTH), .WIDTH(WIDTH), .TAG_W(TAG_W),
      .TIME_W(TIME_W), .LATENCY(LATENCY)
   ) u_lanes (
      .move_i(move), .tag_i(tag_q), .now_i(cycle_i),
      .valid_o(enq_valid_o), .tag_o(enq_tag_o), .time_o(enq_time_o)
   );

   xfer_compact #(
      .SRC_DEPTH(SRC_DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W), .CNT_W(CNT_W)
   ) u_compact (
      .cnt_i(cnt_q), .move_i(move), .tag_i(tag_q), .rt_i(rt_q),
      .push_i(push_valid_i), .push_tag_i(push_tag_i), .push_rt_i(push_time_i),
      .tag_o(tag_d), .rt_o(rt_d), .cnt_o(cnt_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int j = 0; j < SRC_DEPTH; j++) begin
            tag_q[j] <= '0;
            rt_q[j]  <= '0;
         end
      end else begin
         cnt_q <= cnt_d;
         for (int j = 0; j < SRC_DEPTH; j++) begin
            tag_q[j] <= tag_d[j];
            rt_q[j]  <= rt_d[j];
         end
      end
   end

   assign src_count_o = cnt_q;
endmodule

// File: rtl/xfer_chk.sv
module xfer_chk #(
   parameter int SRC_DEPTH = 4,
   parameter int DST_DEPTH = 3,
   parameter int WIDTH     = 2,
   parameter int LATENCY   = 3,
   parameter int TIME_W    = 16,
   parameter int CNT_W     = 3,
   parameter int DCNT_W    = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [TIME_W-1:0]       cycle_i,
   input logic                    push_valid_i,
   input logic [DCNT_W-1:0]       dst_count_i,
   input logic [CNT_W-1:0]        src_count_o,
   input logic [WIDTH-1:0]        enq_valid_o,
   input logic [WIDTH*TIME_W-1:0] enq_time_o
);
   logic live_q;
   int   moved_n, accepted_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   always_comb begin
      moved_n    = $countones(enq_valid_o);
      accepted_n = (push_valid_i && (int'(src_count_o) - moved_n < SRC_DEPTH)) ? 1 : 0;
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(src_count_o) <= SRC_DEPTH);

   a_r4_dst_room: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dst_count_i) <= DST_DEPTH) |-> (int'(dst_count_i) + moved_n <= DST_DEPTH));

   a_r6_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (int'(src_count_o) ==
                  int'($past(src_count_o)) - $past(moved_n) + $past(accepted_n)));

   for (genvar k = 0; k < WIDTH; k++) begin : g_lane
      a_r8_stamp: assert property (@(posedge clk) disable iff (!rst_n)
         enq_valid_o[k] |-> (enq_time_o[k*TIME_W +: TIME_W] == cycle_i + TIME_W'(LATENCY)));
      if (k > 0) begin : g_contig
         a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
            enq_valid_o[k] |-> enq_valid_o[k-1]);
      end
   end
endmodule

bind latency_stage_xfer xfer_chk #(
   .SRC_DEPTH(SRC_DEPTH), .DST_DEPTH(DST_DEPTH), .WIDTH(WIDTH),
   .LATENCY(LATENCY), .TIME_W(TIME_W), .CNT_W(CNT_W), .DCNT_W(DCNT_W)
) u_xfer_chk (
   .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .push_valid_i(push_valid_i),
   .dst_count_i(dst_count_i), .src_count_o(src_count_o),
   .enq_valid_o(enq_valid_o), .enq_time_o(enq_time_o)
);

// File: tb/latency_stage_xfer_test.sv
module latency_stage_xfer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SRC_DEPTH  = 4;
   localparam int DST_DEPTH  = 3;
   localparam int WIDTH      = 2;
   localparam int LATENCY    = 3;
   localparam int TAG_W      = 4;
   localparam int TIME_W     = 16;
   localparam int CNT_W      = $clog2(SRC_DEPTH + 1);
   localparam int DCNT_W     = $clog2(DST_DEPTH + 1);
   localparam int RUN_CYCLES = 600;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [TIME_W-1:0]       cycle_i = '0;
   logic                    push_valid_i = 1'b0;
   logic [TAG_W-1:0]        push_tag_i = '0;
   logic [TIME_W-1:0]       push_time_i = '0;
   logic [DCNT_W-1:0]       dst_count_i = '0;
   logic [CNT_W-1:0]        src_count_o;
   logic [WIDTH-1:0]        enq_valid_o;
   logic [WIDTH*TAG_W-1:0]  enq_tag_o;
   logic [WIDTH*TIME_W-1:0] enq_time_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int mtag[$];
   int mrt[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   latency_stage_xfer #(
      .SRC_DEPTH(SRC_DEPTH), .DST_DEPTH(DST_DEPTH), .WIDTH(WIDTH),
      .LATENCY(LATENCY), .TAG_W(TAG_W), .TIME_W(TIME_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .push_valid_i(push_valid_i),
      .push_tag_i(push_tag_i), .push_time_i(push_time_i), .dst_count_i(dst_count_i),
      .src_count_o(src_count_o), .enq_valid_o(enq_valid_o),
      .enq_tag_o(enq_tag_o), .enq_time_o(enq_time_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycle_i);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      int tagc;
      int oosq;
      tagc = 0;
      oosq = 0;
      repeat (3) @(posedge clk);
      #1;
      check(src_count_o == 0, "R1 count in reset", int'(src_count_o), 0);
      check(enq_valid_o == '0, "R1 lanes in reset", int'(enq_valid_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(src_count_o == 0, "R1 count after reset", int'(src_count_o), 0);
      check(enq_valid_o == '0, "R1 lanes after reset", int'(enq_valid_o), 0);

      for (int c = 1; c <= RUN_CYCLES; c++) begin
         int ev[WIDTH];
         int et[WIDTH];
         int idx[WIDTH];
         int m;
         int dst;
         int room;
         @(negedge clk);
         dst = (c / 4) % (DST_DEPTH + 1);
         if (c > 500) dst = 0;
         cycle_i     = TIME_W'(c);
         dst_count_i = DCNT_W'(dst);
         m = 0;
         for (int k = 0; k < WIDTH; k++) begin ev[k] = 0; et[k] = 0; idx[k] = 0; end
         for (int i = 0; i < mtag.size() && i < WIDTH; i++) begin
            if (mrt[i] <= c && dst + m < DST_DEPTH) begin
               ev[m] = 1; et[m] = mtag[i]; idx[m] = i;
               if (i > 0 && mrt[0] > c) oosq++;
               m++;
            end
         end
         room = (mtag.size() - m) < SRC_DEPTH;
         push_valid_i = room && ((c % 5) != 4) && (c <= 540);
         push_tag_i   = TAG_W'(tagc);
         push_time_i  = TIME_W'(c + ((c > 440) ? 0 : ((tagc * 5) % 7)));
         #1;
         check(int'(src_count_o) == mtag.size() && int'(src_count_o) <= SRC_DEPTH,
               "R6/R7 occupancy", int'(src_count_o), mtag.size());
         for (int k = 0; k < WIDTH; k++) begin
            check(int'(enq_valid_o[k]) == ev[k], "R2/R3/R4 lane valid",
                  int'(enq_valid_o[k]), ev[k]);
            if (ev[k] != 0) begin
               check(int'(enq_tag_o[k*TAG_W +: TAG_W]) == et[k], "R5 lane order",
                     int'(enq_tag_o[k*TAG_W +: TAG_W]), et[k]);
               check(int'(enq_time_o[k*TIME_W +: TIME_W]) == c + LATENCY, "R8 new ready cycle",
                     int'(enq_time_o[k*TIME_W +: TIME_W]), c + LATENCY);
               check(mrt[idx[k]] <= c, "R3 not before ready", mrt[idx[k]], c);
            end
         end
         @(posedge clk);
         for (int k = WIDTH - 1; k >= 0; k--) begin
            if (ev[k] != 0) begin
               mtag.delete(idx[k]);
               mrt.delete(idx[k]);
            end
         end
         if (push_valid_i) begin
            mtag.push_back(tagc);
            mrt.push_back(int'(push_time_i));
            tagc = (tagc + 1) % (1 << TAG_W);
         end
      end
      @(negedge clk);
      push_valid_i = 1'b0;
      #1;
      check(oosq > 0, "R3 younger passed blocked older", oosq, 1);
      check(int'(src_count_o) == mtag.size(), "R6 final occupancy", int'(src_count_o), mtag.size());
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * (RUN_CYCLES + 200));
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
   end
endmodule